// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date: seconds, minutes, hours, day of the week, day of the month, month and a three-digit year. A divider on the 32.768 kHz input clock produces a one-cycle strobe once per second, and each strobe advances the calendar by one second. The carry ripples through month lengths and the full Gregorian leap-year rule.

Software sets and reads each field in BCD through a small write port (select, data, strobe) and a combinational read port (select, data). Writes take effect only while the master enable is high. The enable also gates the divider: a rising edge restarts it with a full count, and a low level freezes both the divider and the calendar. The per-second strobe and all current fields, encoded in BCD, are driven out so that neighbouring alarm logic can compare against them.

Top module: `bcd_calendar`

## Requirements
- R1: The divider restarts on a rising edge of `en`. `tick_1hz` is first high in the DIV-th cycle after the cycle that first samples `en` high, and then once every DIV cycles. It is high for exactly one cycle and only while `en` is high. On the clock edge where it is high, the calendar advances by one second.
- R2: While `en` is low, `tick_1hz` stays low and every field holds its value. On re-enable the count starts again from zero and does not resume a partial second.
- R3: Seconds wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours. Hours wrap from 23 to 0 with a carry into the day.
- R4: On a day carry, day-of-week goes from 6 to 0 or otherwise up by one. Day-of-month returns to 1 after the last day of the month (31,28,31,30,31,30,31,31,30,31,30,31, January first) and otherwise goes up by one.
- R5: February has 29 days when the full year (1900 plus the stored value) is divisible by 4 and either not divisible by 100 or divisible by 400.
- R6: A carry out of December sets the month to January and increments the year. Year 999 wraps to 0.
- R7: The fields are presented in BCD. Month is shown as 1 to 12. The year uses bits 11:8 for hundreds and bits 7:0 for tens and units. The `rd_sel`/`wr_sel` codes are 0 sec, 1 min, 2 hour, 3 day-of-week, 4 day-of-month, 5 month, 6 year. Code 7 reads 0. Narrower fields sit in bits 7:0 with bits 11:8 reading 0.
- R8: A write (`wr_en` high) loads the selected field from `wr_data` in BCD on the next edge when `en` is high. It is ignored when `en` is low.
- R9: A write on the same edge as a per-second advance wins for the written field. The carry into the other fields still follows the field's old value.
- R10: After reset the time is 00:00:00, day-of-week 0, day 1, month 1, year 000, `en` is treated as previously low, and `tick_1hz` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Master enable for divider, counting and writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 12 | BCD write value |
| rd_sel | input | 3 | Field select for reads |
| rd_data | output | 12 | BCD value of the selected field |
| tick_1hz | output | 1 | One-cycle per-second strobe |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| wday_bcd | output | 8 | Day of week 0..6, BCD |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month 1..12, BCD |
| year_bcd | output | 12 | Three-digit year, BCD |

## Verification
The range assertions on day-of-week and day-of-month take for granted that software writes only legal BCD values for real calendar dates. The stimulus therefore writes only such dates. It sweeps the last four days of every month across years that exercise each branch of the leap rule, plus the year wrap at 999. The collision case writes exactly on the strobe edge. It is found by waiting for the strobe, never by counting from a guessed phase.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int DIV = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [11:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [11:0] rd_data,
  output logic        tick_1hz,
  output logic [7:0]  sec_bcd,
  output logic [7:0]  min_bcd,
  output logic [7:0]  hour_bcd,
  output logic [7:0]  wday_bcd,
  output logic [7:0]  mday_bcd,
  output logic [7:0]  mon_bcd,
  output logic [11:0] year_bcd
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  logic [CW-1:0] cnt;
  logic          en_q;
  logic [5:0]    sec, min;
  logic [4:0]    hour, mday;
  logic [2:0]    wday;
  logic [3:0]    mon;
  logic [9:0]    yr;

  assign tick_1hz = en && en_q && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else begin
      en_q <= en;
      if (en && !en_q)  cnt <= '0;
      else if (tick_1hz) cnt <= '0;
      else if (en)       cnt <= cnt + 1'b1;
    end

  logic [11:0] full_yr;
  logic        leap;
  logic [4:0]  dim;
  assign full_yr = 12'd1900 + 12'(yr);
  assign leap = (full_yr[1:0] == 2'b00) &&
                ((full_yr % 12'd100 != 12'd0) || (full_yr % 12'd400 == 12'd0));

  always_comb
    case (mon)
      4'd1:                      dim = leap ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10:   dim = 5'd30;
      default:                   dim = 5'd31;
    endcase

  logic c_sec, c_min, c_hr, c_day, c_mon;
  assign c_sec = sec >= 6'd59;
  assign c_min = c_sec && (min >= 6'd59);
  assign c_hr  = c_min && (hour >= 5'd23);
  assign c_day = c_hr && (mday >= dim);
  assign c_mon = c_day && (mon >= 4'd11);

  logic       we;
  logic [6:0] wv;
  assign we = wr_en && en;
  assign wv = from_bcd(wr_data[7:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
      wday <= '0;
      mday <= 5'd1;
      mon  <= '0;
      yr   <= '0;
    end else begin
      if (we && wr_sel == 3'd0)      sec <= 6'(wv);
      else if (tick_1hz)             sec <= c_sec ? 6'd0 : sec + 6'd1;

      if (we && wr_sel == 3'd1)      min <= 6'(wv);
      else if (tick_1hz && c_sec)    min <= c_min ? 6'd0 : min + 6'd1;

      if (we && wr_sel == 3'd2)      hour <= 5'(wv);
      else if (tick_1hz && c_min)    hour <= c_hr ? 5'd0 : hour + 5'd1;

      if (we && wr_sel == 3'd3)      wday <= 3'(wv);
      else if (tick_1hz && c_hr)     wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;

      if (we && wr_sel == 3'd4)      mday <= 5'(wv);
      else if (tick_1hz && c_hr)     mday <= c_day ? 5'd1 : mday + 5'd1;

      if (we && wr_sel == 3'd5)      mon <= 4'(wv - 7'd1);
      else if (tick_1hz && c_day)    mon <= c_mon ? 4'd0 : mon + 4'd1;

      if (we && wr_sel == 3'd6)      yr <= 10'(wr_data[11:8]) * 10'd100 + 10'(wv);
      else if (tick_1hz && c_mon)    yr <= (yr >= 10'd999) ? 10'd0 : yr + 10'd1;
    end

  assign sec_bcd  = to_bcd(7'(sec));
  assign min_bcd  = to_bcd(7'(min));
  assign hour_bcd = to_bcd(7'(hour));
  assign wday_bcd = to_bcd(7'(wday));
  assign mday_bcd = to_bcd(7'(mday));
  assign mon_bcd  = to_bcd(7'(mon) + 7'd1);
  assign year_bcd = {4'(yr / 10'd100), to_bcd(7'(yr % 10'd100))};

  always_comb
    case (rd_sel)
      3'd0:    rd_data = {4'd0, sec_bcd};
      3'd1:    rd_data = {4'd0, min_bcd};
      3'd2:    rd_data = {4'd0, hour_bcd};
      3'd3:    rd_data = {4'd0, wday_bcd};
      3'd4:    rd_data = {4'd0, mday_bcd};
      3'd5:    rd_data = {4'd0, mon_bcd};
      3'd6:    rd_data = year_bcd;
      default: rd_data = 12'd0;
    endcase
endmodule

// File: rtl/calendar_props.sv
module calendar_props (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        wr_en,
  input logic        tick_1hz,
  input logic [7:0]  sec_bcd,
  input logic [7:0]  min_bcd,
  input logic [7:0]  hour_bcd,
  input logic [7:0]  wday_bcd,
  input logic [7:0]  mday_bcd,
  input logic [7:0]  mon_bcd,
  input logic [11:0] year_bcd
);
  logic [59:0] fields;
  assign fields = {sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd, year_bcd};

  assert_tick_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> en);

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);

  assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fields));

  assert_second_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_en) |=> (sec_bcd != $past(sec_bcd)));

  assert_wday_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wday_bcd <= 8'h06);

  assert_mday_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mday_bcd >= 8'h01) && (mday_bcd <= 8'h31));
endmodule

bind bcd_calendar calendar_props u_props (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .tick_1hz(tick_1hz),
  .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
  .wday_bcd(wday_bcd), .mday_bcd(mday_bcd), .mon_bcd(mon_bcd),
  .year_bcd(year_bcd)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
  localparam int DIV = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] rd_data, year_bcd;
  logic tick_1hz;
  logic [7:0] sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd;

  bcd_calendar #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick_1hz(tick_1hz),
    .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd), .wday_bcd(wday_bcd),
    .mday_bcd(mday_bcd), .mon_bcd(mon_bcd), .year_bcd(year_bcd));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  int ms, mm, mh, mw, md, mo, my;

  function automatic int b2(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int y3(input int v);
    return ((v / 100) << 8) | b2(v % 100);
  endfunction
  function automatic int days_in(input int m, input int y);
    int fy = 1900 + y;
    if (m == 2) return ((fy % 4 == 0) && ((fy % 100 != 0) || (fy % 400 == 0))) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [59:0] expv();
    return {8'(b2(ms)), 8'(b2(mm)), 8'(b2(mh)), 8'(b2(mw)), 8'(b2(md)), 8'(b2(mo)), 12'(y3(my))};
  endfunction

  task automatic chk_all(input string req);
    chk(req, 64'({sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd, year_bcd}), 64'(expv()));
  endtask

  task automatic advance();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mw = (mw + 1) % 7;
      md++;
      if (md > days_in(mo, my)) begin
        md = 1; mo++;
        if (mo == 13) begin mo = 1; my = (my + 1) % 1000; end
      end
    end
  endtask

  // waits for the strobe, lets it take effect, returns number of waits
  task automatic step(output int waits);
    waits = 0;
    while (!tick_1hz) begin @(negedge clk); waits++; end
    @(negedge clk);
    advance();
  endtask

  task automatic set_time(input int s, input int m, input int h, input int w,
                          input int d, input int mon, input int y);
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    for (int k = 0; k < 7; k++) begin
      wr_en = 1'b1;
      wr_sel = 3'(k);
      case (k)
        0: wr_data = 12'(b2(s));
        1: wr_data = 12'(b2(m));
        2: wr_data = 12'(b2(h));
        3: wr_data = 12'(b2(w));
        4: wr_data = 12'(b2(d));
        5: wr_data = 12'(b2(mon));
        default: wr_data = 12'(y3(y));
      endcase
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    int years [7] = '{0, 99, 100, 123, 124, 200, 999};
    ms = 0; mm = 0; mh = 0; mw = 0; md = 1; mo = 1; my = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R10 reset fields");
    chk("R10 reset tick", 64'(tick_1hz), 64'd0);

    // R1: first strobe DIV cycles after enabling
    en = 1'b1;
    w = 0;
    do begin @(negedge clk); w++; end while (!tick_1hz);
    chk("R1 first strobe delay", 64'(w), 64'(DIV));
    @(negedge clk); advance();
    chk_all("R1 first second");
    step(w);
    chk("R1 strobe period", 64'(w), 64'(DIV - 1));
    chk_all("R3 second count");

    // R2 / R8: disable mid-count, writes ignored, no strobe
    repeat (5) @(negedge clk);
    en = 1'b0;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h045;
    @(negedge clk);
    wr_sel = 3'd6; wr_data = 12'h321;
    @(negedge clk);
    wr_en = 1'b0;
    w = 0;
    for (int i = 0; i < 3 * DIV; i++) begin @(negedge clk); if (tick_1hz) w++; end
    chk("R2 no strobe while off", 64'(w), 64'd0);
    chk_all("R8 write ignored while off");
    en = 1'b1;
    w = 0;
    do begin @(negedge clk); w++; end while (!tick_1hz);
    chk("R2 restart full count", 64'(w), 64'(DIV));
    @(negedge clk); advance();
    chk_all("R2 resumes counting");

    // R4 R5 R6: month ends across leap classes and year wrap
    foreach (years[yi]) begin
      for (int mn = 1; mn <= 12; mn++) begin
        for (int dd = 28; dd <= 31; dd++) begin
          if (dd <= days_in(mn, years[yi])) begin
            set_time(59, 59, 23, dd % 7, dd, mn, years[yi]);
            step(w);
            chk_all($sformatf("R4 R5 R6 day carry y=%0d m=%0d d=%0d", years[yi], mn, dd));
          end
        end
      end
    end

    // R3: continuous run across hour and midnight into a leap day
    set_time(0, 59, 22, 3, 28, 2, 124);
    for (int i = 0; i < 3700; i++) begin
      step(w);
      chk_all("R3 cascade run");
      if (i == 100) chk("R1 strobe period in run", 64'(w), 64'(DIV - 1));
    end

    // R7: read port codes
    for (int k = 0; k < 8; k++) begin
      int e;
      rd_sel = 3'(k);
      #0.5;
      case (k)
        0: e = b2(ms); 1: e = b2(mm); 2: e = b2(mh); 3: e = b2(mw);
        4: e = b2(md); 5: e = b2(mo); 6: e = y3(my); default: e = 0;
      endcase
      chk($sformatf("R7 read code %0d", k), 64'(rd_data), 64'(e));
    end

    // R9: write on the strobe edge wins, carry still from old value
    set_time(59, 10, 10, 2, 15, 7, 87);
    while (!tick_1hz) @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h030;
    @(negedge clk);
    wr_en = 1'b0;
    advance();
    ms = 30;
    chk_all("R9 write beats advance");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule